// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block moves Ethernet-style frames between a byte stream and buffers in shared memory, steered by two circular rings of buffer descriptors: one ring for receive and one for transmit. A descriptor is two 32-bit words. The first word holds a 16-bit status field in bits 31:16 and a 16-bit byte length in bits 15:0. The second word, at offset +4, holds the buffer's byte address. Descriptors sit 8 bytes apart. Ownership passes between software and the engine only through status bits in memory. The engine never alters a descriptor that software still owns.

Software programs a base address for each ring, which also sets that ring's current pointer. It then writes an activate command. The engine walks the ring until it meets a descriptor it does not own, and then goes idle until the next activate command. On transmit, each owned descriptor's buffer is read byte by byte and presented on the output stream, and the descriptor is handed back. On receive, the incoming frame is written into the buffer of the current free descriptor. The engine then writes back the length and flags, handing the descriptor back with a frame-end mark and, where needed, an error mark.

Each ring has its own memory port: 32-bit words, byte enables, and read data that returns one cycle after the request.

Top module: `descRingDma`

## Requirements
- R1: After reset both rings are idle: `rxPolling`, `txPolling`, `rxReady`, `txValid`, `rxMemEn` and `txMemEn` are all low.
- R2: A register write with `regSel`=3 (transmit) or `regSel`=2 (receive) starts polling of that ring only if `regWdata` bit 24 is set. Without bit 24 the write has no effect and the ring stays idle.
- R3: A descriptor's first word is {status[15:0], length[15:0]}. Its second word, at +4, is the buffer pointer. Consecutive descriptors are 8 bytes apart. `regSel`=0 sets the receive ring base and `regSel`=1 sets the transmit ring base, and each base write also moves that ring's pointer to the base.
- R4: A transmit descriptor whose status bit 15 (READY) is set has its `length` bytes streamed from its pointer, in ascending address order, with one `txValid` pulse per byte. Pointers need not be word aligned.
- R5: `txEnd` is high on the final byte of a transmit descriptor only when that descriptor's status bit 11 (LAST) is set. `txAppendCrc` equals status bit 10 (append CRC) on every byte of the descriptor.
- R6: After the bytes are sent, the transmit descriptor's first word is written back with bit 15 cleared and all other status bits and the length unchanged.
- R7: Receive: a descriptor whose status bit 15 (EMPTY) is set takes the next frame. Each byte is written to pointer+index, and no byte beyond the stored length is touched. The write-back sets the length to the frame's byte count, which includes the 4-byte check sequence, clears bit 15, sets bit 11 (LAST) and keeps bit 13.
- R8: After a descriptor whose status bit 13 (WRAP) is set, the ring continues at its base address. Otherwise it continues at the next descriptor, 8 bytes on.
- R9: When the current descriptor is not owned (bit 15 clear), polling stops with the pointer left on that descriptor. The next activate command resumes from that same descriptor.
- R10: A received frame longer than `MAX_FRAME` (default 1522) stores only its first `MAX_FRAME` bytes and writes back length `MAX_FRAME` with status bit 0 (ERROR) set. A frame of exactly `MAX_FRAME` bytes is stored whole with bit 0 clear.
- R11: A frame whose final byte arrives with `rxBad` high is written back with status bit 0 set and bit 15 cleared, so it is still returned to software.
- R12: `rxReady` is high only while a receive buffer is open. A byte is taken on a clock edge where both `rxValid` and `rxReady` are high, and `rxEnd` marks the frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 rx base, 1 tx base, 2 rx activate, 3 tx activate |
| regWdata | input | 32 | Register write data |
| rxMemEn | output | 1 | Receive memory port request |
| rxMemWe | output | 1 | Receive memory port write |
| rxMemBe | output | 4 | Receive memory byte enables |
| rxMemAddr | output | 32 | Receive memory byte address |
| rxMemWdata | output | 32 | Receive memory write data |
| rxMemRdata | input | 32 | Receive memory read data, one cycle after request |
| txMemEn | output | 1 | Transmit memory port request |
| txMemWe | output | 1 | Transmit memory port write |
| txMemBe | output | 4 | Transmit memory byte enables |
| txMemAddr | output | 32 | Transmit memory byte address |
| txMemWdata | output | 32 | Transmit memory write data |
| txMemRdata | input | 32 | Transmit memory read data, one cycle after request |
| rxValid | input | 1 | Incoming byte valid |
| rxData | input | 8 | Incoming byte |
| rxEnd | input | 1 | Incoming byte is the frame's last |
| rxBad | input | 1 | Frame cut short, sampled with the last byte |
| rxReady | output | 1 | Engine can take an incoming byte |
| txValid | output | 1 | Outgoing byte valid |
| txData | output | 8 | Outgoing byte |
| txEnd | output | 1 | Outgoing byte ends the frame |
| txAppendCrc | output | 1 | CRC should be appended to this frame |
| rxPolling | output | 1 | Receive ring is active |
| txPolling | output | 1 | Transmit ring is active |

## Verification
The assertions assume that both ring bases are 8-byte aligned, that base registers are written only while their ring is idle, and that memory returns read data exactly one cycle after each request. The stimulus keeps to this. Both bases are aligned constants written before any activate command. Descriptors are rewritten only after the ring has gone idle. The bench memory answers every read on the next edge. Incoming bytes are held stable until they are taken, and each frame is at most a few bytes longer than the length limit, so the sender always finishes.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int BE_W = DATA_W / 8;

  // status bit positions inside the upper half of descriptor word 0
  localparam int BIT_OWN  = 15;
  localparam int BIT_WRAP = 13;
  localparam int BIT_LAST = 11;
  localparam int BIT_TC   = 10;
  localparam int BIT_ERR  = 0;

  localparam int ACT_BIT    = 24;
  localparam int DESC_BYTES = 8;
  localparam int PTR_OFS    = 4;

  localparam logic [1:0] SEL_RX_BASE = 2'd0;
  localparam logic [1:0] SEL_TX_BASE = 2'd1;
  localparam logic [1:0] SEL_RX_ACT  = 2'd2;
  localparam logic [1:0] SEL_TX_ACT  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT_RD, S_STAT_WT, S_PTR_RD, S_PTR_WT, S_MOVE, S_MOVE_WT, S_WBACK
  } ringState_e;

  typedef struct packed {
    logic rdStat;
    logic capStat;
    logic rdPtr;
    logic capPtr;
    logic byteGo;
    logic writeBack;
    logic advance;
  } ringStrobe_t;
endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import dmaPkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        actStart,
  input  logic        ownNow,
  input  logic        byteReq,
  input  logic        frameDone,
  output ringStrobe_t strobe,
  output logic        polling,
  output logic        moveOpen
);
  ringState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    moveOpen  = 1'b0;
    case (state)
      S_IDLE:    if (actStart) nextState = S_STAT_RD;
      S_STAT_RD: begin
        strobe.rdStat = 1'b1;
        nextState     = S_STAT_WT;
      end
      S_STAT_WT: begin
        if (ownNow) begin
          strobe.capStat = 1'b1;
          nextState      = S_PTR_RD;
        end else begin
          nextState = S_IDLE;
        end
      end
      S_PTR_RD: begin
        strobe.rdPtr = 1'b1;
        nextState    = S_PTR_WT;
      end
      S_PTR_WT: begin
        strobe.capPtr = 1'b1;
        nextState     = S_MOVE;
      end
      S_MOVE: begin
        if (IS_TX) begin
          if (frameDone) nextState = S_WBACK;
          else if (byteReq) begin
            strobe.byteGo = 1'b1;
            nextState     = S_MOVE_WT;
          end
        end else begin
          moveOpen = 1'b1;
          if (byteReq) strobe.byteGo = 1'b1;
          if (frameDone) nextState = S_WBACK;
        end
      end
      S_MOVE_WT: nextState = S_MOVE;
      S_WBACK: begin
        strobe.writeBack = 1'b1;
        strobe.advance   = 1'b1;
        nextState        = S_STAT_RD;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign polling = (state != S_IDLE);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!polling && !actStart) |=> !polling); // R2
  AST_WB_THEN_POLL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |=> strobe.rdStat); // R8
endmodule

// File: rtl/rxPath.sv
module rxPath
  import dmaPkg::*;
#(
  parameter int MAX_FRAME = 1522
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseData,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic              rxBad,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [BE_W-1:0]   memBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              ownNow
);
  localparam logic [HALF_W-1:0] MAX_LEN = HALF_W'(MAX_FRAME);

  logic [ADDR_W-1:0] baseReg, curPtr, bufPtr, byteAddr;
  logic [HALF_W-1:0] statReg, cnt, wbStat;
  logic              errFlag, room;

  assign byteAddr = bufPtr + ADDR_W'(cnt);
  assign room     = (cnt < MAX_LEN);
  assign ownNow   = memRdata[HALF_W + BIT_OWN];

  always_comb begin
    wbStat           = statReg;
    wbStat[BIT_OWN]  = 1'b0;
    wbStat[BIT_LAST] = 1'b1;
    wbStat[BIT_ERR]  = errFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      curPtr  <= '0;
      bufPtr  <= '0;
      statReg <= '0;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else begin
      if (baseWe) begin
        baseReg <= baseData;
        curPtr  <= baseData;
      end
      if (strobe.capStat) statReg <= memRdata[DATA_W-1 -: HALF_W];
      if (strobe.capPtr) begin
        bufPtr  <= memRdata;
        cnt     <= '0;
        errFlag <= 1'b0;
      end
      if (strobe.byteGo) begin
        if (room) cnt <= cnt + 1'b1;
        else      errFlag <= 1'b1;
        if (rxEnd && rxBad) errFlag <= 1'b1;
      end
      if (strobe.advance)
        curPtr <= statReg[BIT_WRAP] ? baseReg : curPtr + ADDR_W'(DESC_BYTES);
    end
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memBe    = '0;
    memAddr  = '0;
    memWdata = '0;
    if (strobe.rdStat) begin
      memEn   = 1'b1;
      memBe   = '1;
      memAddr = curPtr;
    end else if (strobe.rdPtr) begin
      memEn   = 1'b1;
      memBe   = '1;
      memAddr = curPtr + ADDR_W'(PTR_OFS);
    end else if (strobe.byteGo && room) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = BE_W'(1) << byteAddr[1:0];
      memAddr  = byteAddr;
      memWdata = {BE_W{rxData}};
    end else if (strobe.writeBack) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = '1;
      memAddr  = curPtr;
      memWdata = {wbStat, cnt};
    end
  end

  AST_RX_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe == '1) |-> (memWdata[HALF_W-1:0] <= MAX_LEN)); // R10
  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe == '1) |-> (!memWdata[HALF_W+BIT_OWN] && memWdata[HALF_W+BIT_LAST])); // R7
  AST_RX_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe != '1) |-> ($countones(memBe) == 1)); // R7
endmodule

// File: rtl/txPath.sv
module txPath
  import dmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [BE_W-1:0]   memBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              ownNow,
  output logic              frameDone,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txEnd,
  output logic              txAppendCrc
);
  logic [ADDR_W-1:0] baseReg, curPtr, bufPtr, byteAddr;
  logic [HALF_W-1:0] statReg, lenReg, cnt, wbStat;
  logic [1:0]        laneReg;
  logic              readPend;

  assign byteAddr  = bufPtr + ADDR_W'(cnt);
  assign ownNow    = memRdata[HALF_W + BIT_OWN];
  assign frameDone = (cnt == lenReg) && !readPend;

  always_comb begin
    wbStat          = statReg;
    wbStat[BIT_OWN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      curPtr   <= '0;
      bufPtr   <= '0;
      statReg  <= '0;
      lenReg   <= '0;
      cnt      <= '0;
      laneReg  <= '0;
      readPend <= 1'b0;
    end else begin
      readPend <= strobe.byteGo;
      if (baseWe) begin
        baseReg <= baseData;
        curPtr  <= baseData;
      end
      if (strobe.capStat) begin
        statReg <= memRdata[DATA_W-1 -: HALF_W];
        lenReg  <= memRdata[HALF_W-1:0];
      end
      if (strobe.capPtr) begin
        bufPtr <= memRdata;
        cnt    <= '0;
      end
      if (strobe.byteGo) begin
        cnt     <= cnt + 1'b1;
        laneReg <= byteAddr[1:0];
      end
      if (strobe.advance)
        curPtr <= statReg[BIT_WRAP] ? baseReg : curPtr + ADDR_W'(DESC_BYTES);
    end
  end

  assign txValid     = readPend;
  assign txData      = memRdata[{laneReg, 3'b000} +: 8];
  assign txEnd       = readPend && statReg[BIT_LAST] && (cnt == lenReg);
  assign txAppendCrc = readPend && statReg[BIT_TC];

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memBe    = '0;
    memAddr  = '0;
    memWdata = '0;
    if (strobe.rdStat) begin
      memEn   = 1'b1;
      memBe   = '1;
      memAddr = curPtr;
    end else if (strobe.rdPtr) begin
      memEn   = 1'b1;
      memBe   = '1;
      memAddr = curPtr + ADDR_W'(PTR_OFS);
    end else if (strobe.byteGo) begin
      memEn   = 1'b1;
      memBe   = '1;
      memAddr = byteAddr;
    end else if (strobe.writeBack) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = '1;
      memAddr  = curPtr;
      memWdata = {wbStat, lenReg};
    end
  end

  AST_TX_WB_AFTER_ALL: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (cnt == lenReg && !readPend)); // R4
  AST_TX_STAT_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStat |-> (memAddr[2:0] == 3'b000)); // R3
  AST_TX_WB_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memWdata[HALF_W+BIT_OWN]); // R6
endmodule

// File: rtl/descRingDma.sv
module descRingDma
  import dmaPkg::*;
#(
  parameter int MAX_FRAME = 1522
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWdata,
  output logic        rxMemEn,
  output logic        rxMemWe,
  output logic [3:0]  rxMemBe,
  output logic [31:0] rxMemAddr,
  output logic [31:0] rxMemWdata,
  input  logic [31:0] rxMemRdata,
  output logic        txMemEn,
  output logic        txMemWe,
  output logic [3:0]  txMemBe,
  output logic [31:0] txMemAddr,
  output logic [31:0] txMemWdata,
  input  logic [31:0] txMemRdata,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxEnd,
  input  logic        rxBad,
  output logic        rxReady,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        txEnd,
  output logic        txAppendCrc,
  output logic        rxPolling,
  output logic        txPolling
);
  ringStrobe_t rxStrobe, txStrobe;
  logic rxBaseWe, txBaseWe, rxStart, txStart;
  logic rxOwn, txOwn, txDone, txOpenUnused;

  assign rxBaseWe = regWe && (regSel == SEL_RX_BASE);
  assign txBaseWe = regWe && (regSel == SEL_TX_BASE);
  assign rxStart  = regWe && (regSel == SEL_RX_ACT) && regWdata[ACT_BIT];
  assign txStart  = regWe && (regSel == SEL_TX_ACT) && regWdata[ACT_BIT];

  ringCtrl #(.IS_TX(1'b0)) u_rxCtrl (
    .clk(clk), .rstN(rstN), .actStart(rxStart), .ownNow(rxOwn),
    .byteReq(rxValid), .frameDone(rxValid && rxEnd),
    .strobe(rxStrobe), .polling(rxPolling), .moveOpen(rxReady)
  );

  rxPath #(.MAX_FRAME(MAX_FRAME)) u_rxPath (
    .clk(clk), .rstN(rstN), .strobe(rxStrobe), .baseWe(rxBaseWe), .baseData(regWdata),
    .rxData(rxData), .rxEnd(rxEnd), .rxBad(rxBad), .memRdata(rxMemRdata),
    .memEn(rxMemEn), .memWe(rxMemWe), .memBe(rxMemBe), .memAddr(rxMemAddr),
    .memWdata(rxMemWdata), .ownNow(rxOwn)
  );

  ringCtrl #(.IS_TX(1'b1)) u_txCtrl (
    .clk(clk), .rstN(rstN), .actStart(txStart), .ownNow(txOwn),
    .byteReq(1'b1), .frameDone(txDone),
    .strobe(txStrobe), .polling(txPolling), .moveOpen(txOpenUnused)
  );

  txPath u_txPath (
    .clk(clk), .rstN(rstN), .strobe(txStrobe), .baseWe(txBaseWe), .baseData(regWdata),
    .memRdata(txMemRdata), .memEn(txMemEn), .memWe(txMemWe), .memBe(txMemBe),
    .memAddr(txMemAddr), .memWdata(txMemWdata), .ownNow(txOwn), .frameDone(txDone),
    .txValid(txValid), .txData(txData), .txEnd(txEnd), .txAppendCrc(txAppendCrc)
  );

  AST_RXREADY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> rxPolling); // R12
  AST_TXVALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txPolling && !txOpenUnused)); // R4
endmodule

// File: tb/descRingDma_tb.sv
module descRingDma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWdata = '0;
  logic rxMemEn, rxMemWe, txMemEn, txMemWe;
  logic [3:0] rxMemBe, txMemBe;
  logic [31:0] rxMemAddr, rxMemWdata, txMemAddr, txMemWdata;
  logic [31:0] rxMemRdata = '0;
  logic [31:0] txMemRdata = '0;
  logic rxValid = 1'b0, rxEnd = 1'b0, rxBad = 1'b0;
  logic [7:0] rxData = '0;
  logic rxReady, txValid, txEnd, txAppendCrc, rxPolling, txPolling;
  logic [7:0] txData;

  logic bdWe = 1'b0;
  logic [3:0] bdBe = '0;
  logic [31:0] bdAddr = '0, bdData = '0;
  logic [31:0] mem [0:MEM_WORDS-1];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [9:0] txq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  descRingDma u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .rxMemEn(rxMemEn), .rxMemWe(rxMemWe), .rxMemBe(rxMemBe), .rxMemAddr(rxMemAddr),
    .rxMemWdata(rxMemWdata), .rxMemRdata(rxMemRdata),
    .txMemEn(txMemEn), .txMemWe(txMemWe), .txMemBe(txMemBe), .txMemAddr(txMemAddr),
    .txMemWdata(txMemWdata), .txMemRdata(txMemRdata),
    .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd), .rxBad(rxBad), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txEnd(txEnd), .txAppendCrc(txAppendCrc),
    .rxPolling(rxPolling), .txPolling(txPolling)
  );

  // shared memory: two ports, read data one cycle after the request
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 32'hEEEE_EEEE;
    end else begin
      if (bdWe)
        for (int b = 0; b < 4; b++) if (bdBe[b]) mem[bdAddr[13:2]][8*b +: 8] <= bdData[8*b +: 8];
      if (rxMemEn) begin
        if (rxMemWe) begin
          for (int b = 0; b < 4; b++)
            if (rxMemBe[b]) mem[rxMemAddr[13:2]][8*b +: 8] <= rxMemWdata[8*b +: 8];
        end else rxMemRdata <= mem[rxMemAddr[13:2]];
      end
      if (txMemEn) begin
        if (txMemWe) begin
          for (int b = 0; b < 4; b++)
            if (txMemBe[b]) mem[txMemAddr[13:2]][8*b +: 8] <= txMemWdata[8*b +: 8];
        end else txMemRdata <= mem[txMemAddr[13:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdByte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[13:2]];
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic bdWrite(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bdWe = 1'b1; bdAddr = a; bdData = d; bdBe = be;
    @(negedge clk);
    bdWe = 1'b0;
  endtask

  task automatic putByte(input logic [31:0] a, input logic [7:0] v);
    bdWrite(a, {4{v}}, 4'b0001 << a[1:0]);
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [15:0] st, input logic [15:0] len,
                         input logic [31:0] ptr);
    bdWrite(a, {st, len}, 4'hF);
    bdWrite(a + 4, ptr, 4'hF);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitIdle(input bit isTx);
    for (int k = 0; k < 8000; k++) begin
      @(negedge clk);
      if (!(isTx ? txPolling : rxPolling)) break;
    end
  endtask

  task automatic sendFrame(input int n, input int kind, input bit bad);
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1;
      rxData  = (kind == 0) ? 8'(8'hA0 + i) : (kind == 1) ? 8'(i * 3) : 8'(i);
      rxEnd   = (i == n - 1);
      rxBad   = bad && (i == n - 1);
      forever begin
        if (rxReady) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    rxValid = 1'b0; rxEnd = 1'b0; rxBad = 1'b0;
  endtask

  task automatic chkFrame(input logic [31:0] ptr, input int n, input int kind, input string req);
    int bad = 0;
    logic [7:0] e, got;
    got = '0; e = '0;
    for (int i = 0; i < n; i++) begin
      e = (kind == 0) ? 8'(8'hA0 + i) : (kind == 1) ? 8'(i * 3) : 8'(i);
      if (rdByte(ptr + i) !== e && bad == 0) begin
        got = rdByte(ptr + i);
        bad = i + 1;
      end
    end
    chk(bad == 0, req, {24'd0, got}, {24'd0, e});
  endtask

  // transmit reference: every clock, compare the outgoing byte with the expected queue
  always @(negedge clk) begin
    if (rstN && txValid) begin
      if (txq.size() == 0) chk(1'b0, "R4 unexpected byte", {22'd0, txEnd, txAppendCrc, txData}, 32'd0);
      else begin
        logic [9:0] exp;
        exp = txq.pop_front();
        chk({txEnd, txAppendCrc, txData} === exp, "R4 R5 stream",
            {22'd0, txEnd, txAppendCrc, txData}, {22'd0, exp});
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(!rxPolling && !txPolling, "R1 polling", {30'd0, rxPolling, txPolling}, 32'd0);
    chk(!rxReady && !txValid, "R1 stream", {30'd0, rxReady, txValid}, 32'd0);
    chk(!rxMemEn && !txMemEn, "R1 memory", {30'd0, rxMemEn, txMemEn}, 32'd0);

    regWrite(2'd0, 32'h0000_0200);
    regWrite(2'd1, 32'h0000_0100);

    // R2 activate without bit 24 is ignored
    regWrite(2'd3, 32'h0000_0001);
    regWrite(2'd2, 32'h00FF_FFFF);
    repeat (4) @(negedge clk);
    chk(!txPolling && !rxPolling, "R2 no start", {30'd0, rxPolling, txPolling}, 32'd0);

    // transmit ring of three descriptors, last one wraps
    for (int i = 0; i < 5; i++) putByte(32'h1000 + i, 8'(8'h10 + i));
    for (int i = 0; i < 3; i++) putByte(32'h1103 + i, 8'(8'h40 + i));
    for (int i = 0; i < 2; i++) putByte(32'h1200 + i, 8'(8'h70 + i));
    putDesc(32'h100, 16'h8C00, 16'd5, 32'h1000);
    putDesc(32'h108, 16'h8000, 16'd3, 32'h1103);
    putDesc(32'h110, 16'hA800, 16'd2, 32'h1200);
    for (int i = 0; i < 5; i++) txq.push_back({(i == 4), 1'b1, 8'(8'h10 + i)});
    for (int i = 0; i < 3; i++) txq.push_back({1'b0, 1'b0, 8'(8'h40 + i)});
    for (int i = 0; i < 2; i++) txq.push_back({(i == 1), 1'b0, 8'(8'h70 + i)});
    regWrite(2'd3, 32'h0100_0000);
    waitIdle(1'b1);
    chk(txq.size() == 0, "R4 all bytes sent", txq.size(), 32'd0);
    chk(mem[32'h100 >> 2] == 32'h0C00_0005, "R6 d0 write-back", mem[32'h100 >> 2], 32'h0C00_0005);
    chk(mem[32'h108 >> 2] == 32'h0000_0003, "R6 d1 write-back", mem[32'h108 >> 2], 32'h0000_0003);
    chk(mem[32'h110 >> 2] == 32'h2800_0002, "R6 d2 write-back", mem[32'h110 >> 2], 32'h2800_0002);
    chk(!txPolling, "R9 tx stops", {31'd0, txPolling}, 32'd0);

    // wrap back to base: re-arm first descriptor and resume
    putDesc(32'h100, 16'h8800, 16'd1, 32'h1000);
    txq.push_back({1'b1, 1'b0, 8'h10});
    regWrite(2'd3, 32'h0100_0000);
    waitIdle(1'b1);
    chk(txq.size() == 0, "R8 R9 resume at base", txq.size(), 32'd0);
    chk(mem[32'h100 >> 2] == 32'h0800_0001, "R6 R8 d0 again", mem[32'h100 >> 2], 32'h0800_0001);

    // receive ring of two descriptors
    chk(!rxReady, "R12 no buffer open", {31'd0, rxReady}, 32'd0);
    putDesc(32'h200, 16'h8000, 16'd0, 32'h2000);
    putDesc(32'h208, 16'hA000, 16'd0, 32'h2800);
    regWrite(2'd2, 32'h0100_0000);
    sendFrame(20, 0, 1'b0);
    sendFrame(30, 1, 1'b1);
    waitIdle(1'b0);
    chk(mem[32'h200 >> 2] == 32'h0800_0014, "R7 r0 write-back", mem[32'h200 >> 2], 32'h0800_0014);
    chkFrame(32'h2000, 20, 0, "R7 frame A bytes");
    chk(rdByte(32'h2000 + 20) == 8'hEE, "R7 no byte past end", {24'd0, rdByte(32'h2000 + 20)}, 32'hEE);
    chk(mem[32'h208 >> 2] == 32'h2801_001E, "R11 truncated frame", mem[32'h208 >> 2], 32'h2801_001E);
    chkFrame(32'h2800, 30, 1, "R7 frame B bytes");
    chk(!rxPolling && !rxReady, "R9 R12 rx stops after wrap", {30'd0, rxPolling, rxReady}, 32'd0);

    // oversize frame into the first descriptor
    putDesc(32'h200, 16'h8000, 16'd0, 32'h2000);
    regWrite(2'd2, 32'h0100_0000);
    sendFrame(1530, 2, 1'b0);
    waitIdle(1'b0);
    chk(mem[32'h200 >> 2] == 32'h0801_05F2, "R10 oversize write-back", mem[32'h200 >> 2], 32'h0801_05F2);
    chkFrame(32'h2000, 1522, 2, "R10 stored bytes");
    chk(rdByte(32'h2000 + 1522) == 8'hEE, "R10 excess dropped", {24'd0, rdByte(32'h2000 + 1522)}, 32'hEE);

    // exactly the maximum: resumes at the second descriptor where it stopped
    putDesc(32'h208, 16'hA000, 16'd0, 32'h2800);
    regWrite(2'd2, 32'h0100_0000);
    sendFrame(1522, 2, 1'b0);
    waitIdle(1'b0);
    chk(mem[32'h208 >> 2] == 32'h2800_05F2, "R10 R9 exact maximum", mem[32'h208 >> 2], 32'h2800_05F2);
    chkFrame(32'h2800, 1522, 2, "R10 exact bytes");
    chk(!rxPolling, "R8 rx wraps and stops", {31'd0, rxPolling}, 32'd0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule